// File: doc/BRIEF.md
# Step/Direction Microstep Translator

This block turns a step pulse and a direction level into current setpoints for the two windings of a bipolar stepper motor. It keeps an electrical position index of 64 positions per electrical cycle. Each rising edge of the step input moves that index forward or backward by one microstep. The microstep size is picked by a three-bit resolution select, which gives full, half, quarter, eighth or sixteenth stepping.

For each winding, the block drives an 8-bit magnitude code for an external current DAC and a polarity bit. Both come from a folded quarter-wave sine table; the second winding runs 90 degrees ahead of the first. The block also drives a per-winding decay request for the current chopper, and a bridge enable that holds the power stage off during reset.

All control inputs pass through the same synchroniser into the system clock domain. They therefore stay aligned with the step edge they belong to.

Top module: `step_translator`

## Requirements
- R1: While `rst` is high (synchronous, active high), `bridge_on` is 0. It becomes 1 on the first clock after reset is released. After reset the position index is 8: both magnitudes are 180, both `*_neg` are 0, both `*_mixed` are 1, and the active increment is full step.
- R2: Each rising edge of `step_in` advances the position exactly once. Holding `step_in` high does not advance it again, and outputs change only after such an edge.
- R3: `dir_in` = 1 adds the increment to the index and `dir_in` = 0 subtracts it, modulo 64.
- R4: `res_sel` bits are {ms3, ms2, ms1}. The codes decode to increments as follows: 3'b000 is full (16), 3'b001 is half (8), 3'b010 is quarter (4), 3'b011 is eighth (2), and 3'b111 is sixteenth (1).
- R5: The codes 3'b100, 3'b101 and 3'b110 are reserved. A step taken with one of them uses the last valid increment, or full step if none has been latched since reset.
- R6: A change on `res_sel` changes no output by itself. It is latched at the next step edge and applies to that step, including when it arrives together with the edge.
- R7: For index p, `a_mag` = round(255·|sin(2πp/64)|) and `a_neg` = 1 when p is in 32..63. `b_mag` uses index q = (p+16) mod 64 by the same rule, and `b_neg` = 1 when q is in 32..63.
- R8: When a step lowers a winding's magnitude, that winding's `*_mixed` goes to 1 (mixed decay). When the magnitude rises or stays equal, it goes to 0 (slow decay).
- R9: Stepping 64/increment times in one direction at a fixed resolution returns every output to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step pulse, asynchronous |
| dir_in | input | 1 | Direction level, 1 = increasing index |
| res_sel | input | 3 | Resolution select {ms3, ms2, ms1} |
| bridge_on | output | 1 | Power bridge enable, 0 during reset |
| a_mag | output | 8 | Winding A DAC magnitude |
| a_neg | output | 1 | Winding A polarity, 1 = negative |
| a_mixed | output | 1 | Winding A decay request, 1 = mixed, 0 = slow |
| b_mag | output | 8 | Winding B DAC magnitude |
| b_neg | output | 1 | Winding B polarity, 1 = negative |
| b_mixed | output | 1 | Winding B decay request, 1 = mixed, 0 = slow |

## Verification
The properties assume that `step_in` stays at each level for longer than the synchroniser depth plus two clocks. This ensures each edge is seen once and the previous update has finished. They also assume that `dir_in` and `res_sel` do not move in the few cycles around a step edge, except when they change in the same cycle as that edge. The stimulus keeps to this in every case. Direction and resolution are set at least four clocks before the edge, or exactly together with it. Each level of the step pulse lasts four or more clocks, and the pulse is followed by an eight-clock low gap. Random pulses draw every resolution code, reserved ones included.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int POS_W = 6;
  localparam int QTR_W = POS_W - 2;
  localparam int MAG_W = 8;
  localparam int RES_W = 3;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [MAG_W-1:0] mag_t;
  typedef logic [QTR_W:0]   qidx_t;

  localparam pos_t  QUARTER  = pos_t'(1) << QTR_W;
  localparam pos_t  HOME_POS = pos_t'(1) << (QTR_W - 1);
  localparam qidx_t HOME_K   = qidx_t'(1) << (QTR_W - 1);

  typedef struct packed {
    logic ok;
    pos_t inc;
  } res_dec_t;

  // {ms3, ms2, ms1} to index increment; reserved codes flagged not ok
  function automatic res_dec_t decode_res(input logic [RES_W-1:0] code);
    res_dec_t r;
    r.ok  = 1'b1;
    r.inc = QUARTER;
    case (code)
      3'b000:  r.inc = QUARTER;
      3'b001:  r.inc = QUARTER >> 1;
      3'b010:  r.inc = QUARTER >> 2;
      3'b011:  r.inc = QUARTER >> 3;
      3'b111:  r.inc = QUARTER >> 4;
      default: r.ok  = 1'b0;
    endcase
    return r;
  endfunction

  // quarter-wave sine, 0..90 degrees in 16 steps, full scale 255
  function automatic mag_t qsine(input qidx_t k);
    case (k)
      5'd0:  return 8'd0;
      5'd1:  return 8'd25;
      5'd2:  return 8'd50;
      5'd3:  return 8'd74;
      5'd4:  return 8'd98;
      5'd5:  return 8'd120;
      5'd6:  return 8'd142;
      5'd7:  return 8'd162;
      5'd8:  return 8'd180;
      5'd9:  return 8'd197;
      5'd10: return 8'd212;
      5'd11: return 8'd225;
      5'd12: return 8'd236;
      5'd13: return 8'd244;
      5'd14: return 8'd250;
      5'd15: return 8'd254;
      5'd16: return 8'd255;
      default: return 8'd0;
    endcase
  endfunction

  localparam mag_t HOME_MAG = qsine(HOME_K);
endpackage

// File: rtl/stp_sync.sv
module stp_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stp_position.sv
module stp_position
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_rise,
  input  logic             fwd,
  input  logic [RES_W-1:0] res_code,
  output pos_t             pos,
  output logic             moved
);
  res_dec_t dec;
  pos_t     inc_q;
  pos_t     inc_use;

  assign dec     = decode_res(res_code);
  assign inc_use = dec.ok ? dec.inc : inc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= HOME_POS;
      inc_q <= QUARTER;
      moved <= 1'b0;
    end else begin
      moved <= step_rise;
      if (step_rise) begin
        inc_q <= inc_use;
        pos   <= fwd ? pos + inc_use : pos - inc_use;
      end
    end
  end
endmodule

// File: rtl/stp_phase.sv
module stp_phase
  import stp_pkg::*;
(
  input  pos_t idx,
  output mag_t mag,
  output logic neg
);
  logic [1:0]       quad;
  logic [QTR_W-1:0] off;
  qidx_t            k;

  assign quad = idx[POS_W-1 -: 2];
  assign off  = idx[QTR_W-1:0];
  assign k    = quad[0] ? (qidx_t'(1) << QTR_W) - qidx_t'(off) : qidx_t'(off);
  assign mag  = qsine(k);
  assign neg  = quad[1];
endmodule

// File: rtl/step_translator.sv
module step_translator
  import stp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic [2:0] res_sel,
  output logic       bridge_on,
  output logic [7:0] a_mag,
  output logic       a_neg,
  output logic       a_mixed,
  output logic [7:0] b_mag,
  output logic       b_neg,
  output logic       b_mixed
);
  localparam int IN_W   = RES_W + 2;
  localparam int PHASES = 2;

  logic [IN_W-1:0] raw_in, sync_in;
  logic            s_step, s_dir, step_q, step_rise;
  logic [RES_W-1:0] s_res;
  pos_t            pos_q;
  logic            moved_q;

  assign raw_in = {res_sel, dir_in, step_in};

  stp_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_in)
  );

  assign s_step = sync_in[0];
  assign s_dir  = sync_in[1];
  assign s_res  = sync_in[IN_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) step_q <= 1'b0;
    else     step_q <= s_step;
  end

  assign step_rise = s_step & ~step_q;

  stp_position u_pos (
    .clk       (clk),
    .rst       (rst),
    .step_rise (step_rise),
    .fwd       (s_dir),
    .res_code  (s_res),
    .pos       (pos_q),
    .moved     (moved_q)
  );

  mag_t mag_n   [PHASES];
  logic neg_n   [PHASES];
  mag_t mag_r   [PHASES];
  logic neg_r   [PHASES];
  logic mixed_r [PHASES];

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
    localparam pos_t OFS = pos_t'(ph) << QTR_W;
    pos_t idx;
    assign idx = pos_q + OFS;

    stp_phase u_lut (
      .idx (idx),
      .mag (mag_n[ph]),
      .neg (neg_n[ph])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        mag_r[ph]   <= HOME_MAG;
        neg_r[ph]   <= 1'b0;
        mixed_r[ph] <= 1'b1;
      end else if (moved_q) begin
        mag_r[ph]   <= mag_n[ph];
        neg_r[ph]   <= neg_n[ph];
        mixed_r[ph] <= (mag_n[ph] < mag_r[ph]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bridge_on <= 1'b0;
    else     bridge_on <= 1'b1;
  end

  assign a_mag   = mag_r[0];
  assign a_neg   = neg_r[0];
  assign a_mixed = mixed_r[0];
  assign b_mag   = mag_r[1];
  assign b_neg   = neg_r[1];
  assign b_mixed = mixed_r[1];
endmodule

// File: rtl/step_translator_chk.sv
module step_translator_chk
  import stp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bridge_on,
  input logic [7:0] a_mag,
  input logic [7:0] b_mag,
  input logic       a_mixed,
  input logic       b_mixed,
  input pos_t       pos,
  input logic       moved
);
  function automatic logic legal_delta(input pos_t d);
    pos_t nd;
    nd = -d;
    return (($countones(d) == 1) && (d <= QUARTER)) ||
           (($countones(nd) == 1) && (nd <= QUARTER));
  endfunction

  p_bridge_off_r1: assert property (@(posedge clk) rst |=> !bridge_on);
  p_home_r1:       assert property (@(posedge clk) rst |=> (pos == HOME_POS));
  p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
                 !$past(moved) |-> $stable(a_mag));
  p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
                 !$past(moved) |-> $stable(b_mag));
  p_inc_legal_r4: assert property (@(posedge clk) disable iff (rst)
                 (pos != $past(pos)) |-> legal_delta(pos - $past(pos)));
  p_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
                 !((a_mag == 8'd0) && (b_mag == 8'd0)));
  p_mixed_fall_a_r8: assert property (@(posedge clk) disable iff (rst)
                 (a_mag < $past(a_mag)) |-> a_mixed);
  p_slow_rise_a_r8: assert property (@(posedge clk) disable iff (rst)
                 (a_mag > $past(a_mag)) |-> !a_mixed);
  p_mixed_fall_b_r8: assert property (@(posedge clk) disable iff (rst)
                 (b_mag < $past(b_mag)) |-> b_mixed);
  p_slow_rise_b_r8: assert property (@(posedge clk) disable iff (rst)
                 (b_mag > $past(b_mag)) |-> !b_mixed);
endmodule

bind step_translator step_translator_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bridge_on (bridge_on),
  .a_mag     (a_mag),
  .b_mag     (b_mag),
  .a_mixed   (a_mixed),
  .b_mixed   (b_mixed),
  .pos       (pos_q),
  .moved     (moved_q)
);

// File: tb/step_translator_test.sv
module step_translator_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic [2:0] res_sel = 3'b000;
  logic       bridge_on, a_neg, a_mixed, b_neg, b_mixed;
  logic [7:0] a_mag, b_mag;

  int n_run = 0;
  int n_fail = 0;
  int ref_pos, ref_inc, ref_am, ref_bm, ref_an, ref_bn, ref_amix, ref_bmix;

  always #2 clk = ~clk;

  step_translator uut (
    .clk (clk), .rst (rst), .step_in (step_in), .dir_in (dir_in),
    .res_sel (res_sel), .bridge_on (bridge_on),
    .a_mag (a_mag), .a_neg (a_neg), .a_mixed (a_mixed),
    .b_mag (b_mag), .b_neg (b_neg), .b_mixed (b_mixed)
  );

  function automatic int exp_mag(input int p);
    real s;
    s = $sin(2.0 * 3.14159265358979 * p / 64.0);
    if (s < 0.0) s = -s;
    return $rtoi(s * 255.0 + 0.5);
  endfunction

  function automatic int bench_inc(input logic [2:0] c);
    case (c)
      3'b000: return 16;
      3'b001: return 8;
      3'b010: return 4;
      3'b011: return 2;
      3'b111: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    check("R7", {ctx, " a_mag"}, a_mag, ref_am);
    check("R7", {ctx, " b_mag"}, b_mag, ref_bm);
    check("R7", {ctx, " a_neg"}, a_neg, ref_an);
    check("R7", {ctx, " b_neg"}, b_neg, ref_bn);
    check("R8", {ctx, " a_mixed"}, a_mixed, ref_amix);
    check("R8", {ctx, " b_mixed"}, b_mixed, ref_bmix);
    check("R1", {ctx, " bridge_on"}, bridge_on, 1);
  endtask

  task automatic model_outputs(input bit stepped);
    int na, nb, q;
    q  = (ref_pos + 16) % 64;
    na = exp_mag(ref_pos);
    nb = exp_mag(q);
    if (stepped) begin
      ref_amix = (na < ref_am) ? 1 : 0;
      ref_bmix = (nb < ref_bm) ? 1 : 0;
    end
    ref_am = na;
    ref_bm = nb;
    ref_an = (ref_pos >= 32) ? 1 : 0;
    ref_bn = (q >= 32) ? 1 : 0;
  endtask

  task automatic model_step(input bit fwd, input logic [2:0] code);
    if (bench_inc(code) != 0) ref_inc = bench_inc(code);
    ref_pos = fwd ? (ref_pos + ref_inc) % 64 : (ref_pos + 64 - ref_inc) % 64;
    model_outputs(1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "bridge_on during reset", bridge_on, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    ref_pos = 8; ref_inc = 16; ref_amix = 1; ref_bmix = 1;
    model_outputs(1'b0);
    check("R1", "home a_mag", a_mag, 180);
    check("R1", "home b_mag", b_mag, 180);
    check_all("R1 after reset");
  endtask

  // same_cycle: direction/resolution change together with the rising edge
  task automatic pulse(input bit fwd, input logic [2:0] code, input int hi, input bit same_cycle,
                       input string ctx);
    @(negedge clk);
    dir_in = fwd;
    res_sel = code;
    if (!same_cycle) repeat (4) @(negedge clk);
    step_in = 1'b1;
    repeat (hi) @(negedge clk);
    step_in = 1'b0;
    repeat (8) @(negedge clk);
    model_step(fwd, code);
    check_all(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int start_pos, sa, sb, san, sbn;
    logic [2:0] codes [5];
    void'($urandom(32'h5EED_0042));
    codes[0] = 3'b000; codes[1] = 3'b001; codes[2] = 3'b010;
    codes[3] = 3'b011; codes[4] = 3'b111;

    do_reset();

    // R5: reserved code right after reset uses full step
    pulse(1'b1, 3'b101, 6, 1'b0, "R5 reserved after reset");
    // R2: long high level yields one advance only
    pulse(1'b1, 3'b000, 40, 1'b0, "R2 long high");
    // R6: resolution change without an edge changes nothing
    @(negedge clk);
    res_sel = 3'b111;
    repeat (20) @(negedge clk);
    model_outputs(1'b0);
    check_all("R6 no edge");
    pulse(1'b1, 3'b111, 6, 1'b0, "R6 applied at edge R4 sixteenth");
    pulse(1'b1, 3'b110, 6, 1'b0, "R5 reserved keeps sixteenth");
    pulse(1'b0, 3'b100, 6, 1'b0, "R5 R3 reserved backward");
    pulse(1'b1, 3'b011, 6, 1'b1, "R6 change with same edge");
    pulse(1'b0, 3'b010, 6, 1'b1, "R6 R3 same edge backward");

    // R9: one electrical cycle per resolution and direction
    for (int ci = 0; ci < 5; ci++) begin
      for (int d = 0; d < 2; d++) begin
        start_pos = ref_pos;
        sa = a_mag; sb = b_mag; san = a_neg; sbn = b_neg;
        for (int s = 0; s < 64 / bench_inc(codes[ci]); s++)
          pulse(d[0], codes[ci], 5, 1'b0, "R4 R3 cycle");
        check("R9", "model position", ref_pos, start_pos);
        check("R9", "a_mag returns", a_mag, sa);
        check("R9", "b_mag returns", b_mag, sb);
        check("R9", "a_neg returns", a_neg, san);
        check("R9", "b_neg returns", b_neg, sbn);
      end
    end

    // random mix, reserved codes included
    for (int i = 0; i < 300; i++) begin
      pulse(1'($urandom), 3'($urandom), 4 + int'($urandom % 8), ($urandom % 5) == 0,
            "R2 R3 R4 R5 random");
    end

    do_reset();
    pulse(1'b0, 3'b000, 5, 1'b0, "R1 R3 full step back from home");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule